// File: doc/BRIEF.md
# Keyed-Start Watchdog Timer

This block is a watchdog peripheral that sits behind a plain register write/read port. A 32-bit up-counter advances on a slow time-base tick, either on every tick or once per programmable power-of-two group of ticks. When it runs past all ones it raises a one-cycle reset request and starts again from the load value. Software keeps the system alive by writing the trigger register. Each trigger write must carry a value that differs from the previous one, and the usual habit is to write the bitwise complement of the last value.

The counter only starts or stops after a two-word key sequence written to the key register. Every register write is posted. The write is held in a per-register holding slot with a pending flag, and it takes effect on the next time-base tick. The slow domain is modelled as a tick enable inside the single system clock domain. A write that reaches a register whose pending flag is still set is discarded, so software polls the status register before it writes. The write port has no back-pressure: a write strobe is accepted or dropped in the cycle it appears, and reads are combinational on the address.

Top module: `wdt_keyseq`

## Requirements
- R1: A key-register (address 3) write of 0xBBBB that takes effect, followed by a write of 0x4444 that takes effect, sets the running state. Running reads back as bit 0 of address 3. The counter does not see the new state until the tick after the one that applied the second word.
- R2: A key write of 0xAAAA that takes effect, followed by a write of 0x5555 that takes effect, clears the running state.
- R3: If the second applied key word does not complete the sequence the first word began, the sequence returns to idle and the running state stays as it was. A lone second word has no effect.
- R4: A write to control (address 0), load (1), trigger (2) or key (3) sets pending bit 0, 1, 2 or 3 of the status register (address 4). The held value takes effect at the next tick after the write cycle, and the pending bit then clears. Status reads zero when nothing is pending.
- R5: A write to a register whose pending bit is set is discarded, and the value already held is the one applied.
- R6: While running, the counter (readable at address 5) rises by one on each counting step. While stopped, and between ticks, it holds its value.
- R7: Control bit 3 enables the prescaler and bits 2:0 give the ratio N. When enabled, the counter steps once every 2^N ticks. When disabled, it steps on every tick. An applied control value affects counting from the following tick.
- R8: An applied trigger write reloads the counter from the load register (address 1) only when its value differs from the last trigger value. That value reads back at address 2 and is 0x1234 after reset. A reload takes priority over the step in the same tick.
- R9: A step from 0xFFFFFFFF reloads the counter from the load register and drives rst_req high for exactly one clock cycle.
- R10: After reset the load register and counter hold 0xFFE20000, which is 60 s of 32768 Hz ticks before overflow. The watchdog is stopped, control reads 0, and status reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick | input | 1 | One-cycle pulse at the 32 kHz time-base rate |
| wr_en | input | 1 | Register write strobe |
| addr | input | 3 | Register address for writes and reads |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data for addr, combinational |
| rst_req | output | 1 | One-cycle reset request on overflow |

## Verification
The assertions assume that tick is a single-cycle pulse synchronous to clk, and that every state change in the slow domain happens only in a tick cycle. They also assume that a write, once accepted, holds its pending flag until a tick. The stimulus drives tick only as isolated one-cycle pulses on the falling edge. It places each write strobe in a cycle of its own, apart from ticks, and it deliberately writes to an already pending register to exercise the drop rule. Load values are chosen close to all ones so that overflow is reached within a few ticks.

// File: rtl/wdt_keyseq_pkg.sv
package wdt_keyseq_pkg;
  localparam int unsigned N_SLOTS   = 4;
  localparam int unsigned SLOT_CTRL = 0;
  localparam int unsigned SLOT_LOAD = 1;
  localparam int unsigned SLOT_TRIG = 2;
  localparam int unsigned SLOT_KEY  = 3;

  localparam logic [2:0] ADR_CTRL  = 3'd0;
  localparam logic [2:0] ADR_LOAD  = 3'd1;
  localparam logic [2:0] ADR_TRIG  = 3'd2;
  localparam logic [2:0] ADR_KEY   = 3'd3;
  localparam logic [2:0] ADR_PEND  = 3'd4;
  localparam logic [2:0] ADR_COUNT = 3'd5;

  localparam logic [15:0] KEY_RUN_A  = 16'hBBBB;
  localparam logic [15:0] KEY_RUN_B  = 16'h4444;
  localparam logic [15:0] KEY_HALT_A = 16'hAAAA;
  localparam logic [15:0] KEY_HALT_B = 16'h5555;

  typedef enum logic [1:0] {
    KS_IDLE     = 2'd0,
    KS_ARM_RUN  = 2'd1,
    KS_ARM_HALT = 2'd2
  } key_state_e;
endpackage

// File: rtl/wdt_post_regs.sv
module wdt_post_regs
  import wdt_keyseq_pkg::*;
#(
  parameter int unsigned DATA_W = 32,
  parameter logic [DATA_W-1:0] RESET_LOAD = '0,
  parameter logic [DATA_W-1:0] TRIG_SEED  = '0
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                tick,
  input  logic                wr_en,
  input  logic [N_SLOTS-1:0]  wr_sel,
  input  logic [DATA_W-1:0]   wdata,
  output logic [N_SLOTS-1:0]  pend,
  output logic [DATA_W-1:0]   ctrl_q,
  output logic [DATA_W-1:0]   load_q,
  output logic [DATA_W-1:0]   trig_last,
  output logic                reload,
  output logic                key_apply,
  output logic [DATA_W-1:0]   key_word
);
  logic [N_SLOTS-1:0][DATA_W-1:0] hold;
  logic [N_SLOTS-1:0]             apply;

  for (genvar g = 0; g < N_SLOTS; g++) begin : g_slot
    assign apply[g] = tick & pend[g];
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        pend[g] <= 1'b0;
        hold[g] <= '0;
      end else if (wr_en && wr_sel[g] && !pend[g]) begin
        pend[g] <= 1'b1;
        hold[g] <= wdata;
      end else if (tick) begin
        pend[g] <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q    <= '0;
      load_q    <= RESET_LOAD;
      trig_last <= TRIG_SEED;
    end else begin
      if (apply[SLOT_CTRL]) ctrl_q    <= hold[SLOT_CTRL];
      if (apply[SLOT_LOAD]) load_q    <= hold[SLOT_LOAD];
      if (apply[SLOT_TRIG]) trig_last <= hold[SLOT_TRIG];
    end
  end

  assign reload    = apply[SLOT_TRIG] && (hold[SLOT_TRIG] != trig_last);
  assign key_apply = apply[SLOT_KEY];
  assign key_word  = hold[SLOT_KEY];
endmodule

// File: rtl/wdt_key_fsm.sv
module wdt_key_fsm
  import wdt_keyseq_pkg::*;
#(
  parameter int unsigned DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              key_apply,
  input  logic [DATA_W-1:0] key_word,
  output logic              running
);
  key_state_e state;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= KS_IDLE;
      running <= 1'b0;
    end else if (key_apply) begin
      unique case (state)
        KS_IDLE: begin
          if (key_word == DATA_W'(KEY_RUN_A))       state <= KS_ARM_RUN;
          else if (key_word == DATA_W'(KEY_HALT_A)) state <= KS_ARM_HALT;
          else                                      state <= KS_IDLE;
        end
        KS_ARM_RUN: begin
          if (key_word == DATA_W'(KEY_RUN_B)) running <= 1'b1;
          state <= KS_IDLE;
        end
        KS_ARM_HALT: begin
          if (key_word == DATA_W'(KEY_HALT_B)) running <= 1'b0;
          state <= KS_IDLE;
        end
        default: state <= KS_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/wdt_step_count.sv
module wdt_step_count #(
  parameter int unsigned CNT_W   = 32,
  parameter int unsigned RATIO_W = 3,
  parameter logic [CNT_W-1:0] RESET_LOAD = '0
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               tick,
  input  logic               running,
  input  logic               ps_en,
  input  logic [RATIO_W-1:0] ratio,
  input  logic               reload,
  input  logic [CNT_W-1:0]   load_val,
  output logic [CNT_W-1:0]   count,
  output logic               rst_req
);
  localparam int unsigned PS_W = (1 << RATIO_W) - 1;

  logic [PS_W-1:0] ps_cnt;
  logic [PS_W-1:0] ps_mask;
  logic            step;

  assign ps_mask = ~({PS_W{1'b1}} << ratio);
  assign step    = !ps_en || (ps_cnt == ps_mask);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      count   <= RESET_LOAD;
      ps_cnt  <= '0;
      rst_req <= 1'b0;
    end else begin
      rst_req <= 1'b0;
      if (reload) begin
        count  <= load_val;
        ps_cnt <= '0;
      end else if (tick && running) begin
        if (step) begin
          ps_cnt <= '0;
          if (count == {CNT_W{1'b1}}) begin
            count   <= load_val;
            rst_req <= 1'b1;
          end else begin
            count <= count + 1'b1;
          end
        end else begin
          ps_cnt <= ps_cnt + 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/wdt_keyseq.sv
module wdt_keyseq
  import wdt_keyseq_pkg::*;
#(
  parameter int unsigned CNT_W     = 32,
  parameter int unsigned RATIO_W   = 3,
  parameter int unsigned TICK_HZ   = 32768,
  parameter int unsigned TIMEOUT_S = 60
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             wr_en,
  input  logic [2:0]       addr,
  input  logic [CNT_W-1:0] wdata,
  output logic [CNT_W-1:0] rdata,
  output logic             rst_req
);
  localparam logic [CNT_W-1:0] TIMEOUT_TICKS = CNT_W'(TICK_HZ * TIMEOUT_S);
  localparam logic [CNT_W-1:0] RESET_LOAD    = {CNT_W{1'b0}} - TIMEOUT_TICKS;
  localparam logic [CNT_W-1:0] TRIG_SEED     = CNT_W'(32'h1234);

  logic [N_SLOTS-1:0] wr_sel;
  logic [N_SLOTS-1:0] pend_w;
  logic [CNT_W-1:0]   ctrl_q, load_q, trig_last, key_word, cnt_w;
  logic               reload, key_apply, run_w;

  always_comb begin
    wr_sel = '0;
    if (addr < 3'(N_SLOTS)) wr_sel[addr[1:0]] = 1'b1;
  end

  wdt_post_regs #(
    .DATA_W(CNT_W), .RESET_LOAD(RESET_LOAD), .TRIG_SEED(TRIG_SEED)
  ) u_regs (
    .clk(clk), .rst_n(rst_n), .tick(tick), .wr_en(wr_en), .wr_sel(wr_sel),
    .wdata(wdata), .pend(pend_w), .ctrl_q(ctrl_q), .load_q(load_q),
    .trig_last(trig_last), .reload(reload), .key_apply(key_apply),
    .key_word(key_word)
  );

  wdt_key_fsm #(.DATA_W(CNT_W)) u_keys (
    .clk(clk), .rst_n(rst_n), .key_apply(key_apply), .key_word(key_word),
    .running(run_w)
  );

  wdt_step_count #(
    .CNT_W(CNT_W), .RATIO_W(RATIO_W), .RESET_LOAD(RESET_LOAD)
  ) u_count (
    .clk(clk), .rst_n(rst_n), .tick(tick), .running(run_w),
    .ps_en(ctrl_q[RATIO_W]), .ratio(ctrl_q[RATIO_W-1:0]),
    .reload(reload), .load_val(load_q), .count(cnt_w), .rst_req(rst_req)
  );

  always_comb begin
    unique case (addr)
      ADR_CTRL:  rdata = ctrl_q;
      ADR_LOAD:  rdata = load_q;
      ADR_TRIG:  rdata = trig_last;
      ADR_KEY:   rdata = CNT_W'(run_w);
      ADR_PEND:  rdata = CNT_W'(pend_w);
      ADR_COUNT: rdata = cnt_w;
      default:   rdata = '0;
    endcase
  end
endmodule

// File: rtl/wdt_keyseq_chk.sv
module wdt_keyseq_chk #(
  parameter int unsigned CNT_W = 32
) (
  input logic             clk,
  input logic             rst_n,
  input logic             tick,
  input logic [3:0]       pend,
  input logic             running,
  input logic [CNT_W-1:0] count,
  input logic             rst_req
);
  assert_pend_clear_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && pend != '0) |=> ((pend & $past(pend)) == '0));

  assert_pend_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !tick |=> ((pend & $past(pend)) == $past(pend)));

  assert_count_still_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !tick |=> $stable(count));

  assert_run_on_tick_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !tick |=> $stable(running));

  assert_rst_from_top_R9: assert property (@(posedge clk) disable iff (!rst_n)
    rst_req |-> ($past(count) == {CNT_W{1'b1}}));

  assert_rst_only_tick_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !tick |=> !rst_req);
endmodule

bind wdt_keyseq wdt_keyseq_chk #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .tick(tick), .pend(pend_w),
  .running(run_w), .count(cnt_w), .rst_req(rst_req)
);

// File: tb/test_wdt_keyseq.sv
module test_wdt_keyseq;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tick = 1'b0;
  logic        wr_en = 1'b0;
  logic [2:0]  addr = 3'd0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        rst_req;

  int unsigned n_cmp = 0;
  int unsigned n_bad = 0;
  logic [31:0] trig_val = 32'h1234;
  logic [31:0] snap;

  always #10 clk = ~clk;

  wdt_keyseq i_wdt_keyseq (
    .clk(clk), .rst_n(rst_n), .tick(tick), .wr_en(wr_en), .addr(addr),
    .wdata(wdata), .rdata(rdata), .rst_req(rst_req)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  task automatic bus_write(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic bus_read(input logic [2:0] a, output logic [31:0] d);
    @(negedge clk);
    addr = a;
    #1 d = rdata;
  endtask

  task automatic one_tick();
    @(negedge clk); tick = 1'b1;
    @(negedge clk); tick = 1'b0;
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) one_tick();
  endtask

  task automatic key(input logic [31:0] w);
    bus_write(3'd3, w);
    one_tick();
  endtask

  task automatic kick();
    trig_val = ~trig_val;
    bus_write(3'd2, trig_val);
    one_tick();
  endtask

  task automatic t_reset();
    logic [31:0] v;
    bus_read(3'd4, v); check("R10 status", v, 32'h0);
    bus_read(3'd5, v); check("R10 count", v, 32'hFFE2_0000);
    bus_read(3'd1, v); check("R10 load", v, 32'hFFE2_0000);
    bus_read(3'd3, v); check("R10 running", v, 32'h0);
    bus_read(3'd0, v); check("R10 ctrl", v, 32'h0);
    bus_read(3'd2, v); check("R8 trigger seed", v, 32'h1234);
    check("R10 rst_req", {31'b0, rst_req}, 32'h0);
  endtask

  task automatic t_posted();
    logic [31:0] v;
    bus_write(3'd0, 32'h2);
    bus_read(3'd4, v); check("R4 ctrl pending", v, 32'h1);
    bus_read(3'd0, v); check("R4 ctrl not yet applied", v, 32'h0);
    bus_write(3'd1, 32'hFFFF_FF00);
    bus_read(3'd4, v); check("R4 load pending", v, 32'h3);
    bus_write(3'd1, 32'h5);
    one_tick();
    bus_read(3'd4, v); check("R4 status clear", v, 32'h0);
    bus_read(3'd0, v); check("R4 ctrl applied", v, 32'h2);
    bus_read(3'd1, v); check("R5 dropped write", v, 32'hFFFF_FF00);
    bus_read(3'd5, v); check("R6 stopped frozen", v, 32'hFFE2_0000);
  endtask

  task automatic t_start();
    logic [31:0] v;
    key(32'hBBBB);
    bus_read(3'd3, v); check("R1 half sequence", v, 32'h0);
    key(32'h4444);
    bus_read(3'd3, v); check("R1 running", v, 32'h1);
    bus_read(3'd5, v); check("R1 no step on start tick", v, 32'hFFE2_0000);
    ticks(5);
    bus_read(3'd5, v); check("R6 five steps", v, 32'hFFE2_0005);
    repeat (4) @(negedge clk);
    bus_read(3'd5, v); check("R6 holds between ticks", v, 32'hFFE2_0005);
  endtask

  task automatic t_trigger();
    logic [31:0] v;
    kick();
    bus_read(3'd5, v); check("R8 reload", v, 32'hFFFF_FF00);
    bus_write(3'd2, trig_val);
    one_tick();
    bus_read(3'd5, v); check("R8 repeat value ignored", v, 32'hFFFF_FF01);
    kick();
    bus_read(3'd5, v); check("R8 complement reloads", v, 32'hFFFF_FF00);
    bus_read(3'd2, v); check("R8 last value", v, trig_val);
  endtask

  task automatic t_prescale();
    logic [31:0] v;
    bus_write(3'd0, 32'hA);
    one_tick();
    bus_read(3'd5, v); check("R7 old setting on apply tick", v, 32'hFFFF_FF01);
    ticks(3);
    bus_read(3'd5, v); check("R7 no step before 4 ticks", v, 32'hFFFF_FF01);
    one_tick();
    bus_read(3'd5, v); check("R7 step at 4 ticks", v, 32'hFFFF_FF02);
    ticks(4);
    bus_read(3'd5, v); check("R7 second step", v, 32'hFFFF_FF03);
    bus_write(3'd0, 32'h0);
    ticks(2);
    bus_read(3'd5, v); check("R7 prescaler off", v, 32'hFFFF_FF04);
  endtask

  task automatic t_sequences();
    logic [31:0] v;
    key(32'hAAAA);
    key(32'h1234);
    bus_read(3'd3, v); check("R3 bad stop word", v, 32'h1);
    key(32'hAAAA);
    key(32'h5555);
    bus_read(3'd3, v); check("R2 stopped", v, 32'h0);
    bus_read(3'd5, snap);
    ticks(3);
    bus_read(3'd5, v); check("R6 frozen while stopped", v, snap);
    key(32'hBBBB);
    key(32'hAAAA);
    key(32'h4444);
    bus_read(3'd3, v); check("R3 bad start word", v, 32'h0);
  endtask

  task automatic t_overflow();
    logic [31:0] v;
    key(32'hBBBB);
    key(32'h4444);
    bus_write(3'd1, 32'hFFFF_FFFC);
    one_tick();
    kick();
    bus_read(3'd5, v); check("R9 reloaded near top", v, 32'hFFFF_FFFC);
    ticks(3);
    bus_read(3'd5, v); check("R9 at all ones", v, 32'hFFFF_FFFF);
    check("R9 no request yet", {31'b0, rst_req}, 32'h0);
    one_tick();
    check("R9 request raised", {31'b0, rst_req}, 32'h1);
    #1 check("R9 count reloaded", rdata, 32'hFFFF_FFFC);
    @(negedge clk);
    check("R9 request one cycle", {31'b0, rst_req}, 32'h0);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_cmp++;
    n_bad++;
    $display("FAIL watchdog: run did not finish");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_posted();
    t_start();
    t_trigger();
    t_prescale();
    t_sequences();
    t_overflow();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule